// File: doc/BRIEF.md
# Periodic System Tick Timer

This block is a down-counting tick timer with a small register window on a 32-bit bus. Software sets a reload value and turns the timer on. From then on the counter steps down by one on every timer tick, which is a single-cycle strobe on `tick_en`. When the counter reaches zero it raises a sticky flag and, if interrupts are on, a one-cycle interrupt pulse. On the tick after that it restarts from the reload value, so it produces a steady periodic event.

Software clears the flag by reading the control/status register. Writing any value to the current-value register zeroes the counter and the flag. The counter then restarts from the reload value on the next tick, and that restart does not raise an interrupt. A reload value of zero parks the counter at zero, which disables the timer without touching the enable bit. While the debug-halt input is high, the counter holds its value.

Register decode accepts only full 32-bit accesses on word-aligned addresses. Reads return data combinationally in the cycle of the access. Any side effect of an access takes effect at the clock edge that ends that cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset, control/status reads 0x00000000, reload reads 0, current value reads 0, and calibration (offset 0xC, read-only) reads 0x00000004.
- R2: The counter advances only on a cycle with `tick_en` high, control bit 0 (enable) set and `dbg_halt` low. With `tick_en` low, it holds its value.
- R3: On a qualifying tick with the counter at zero, the counter loads the reload value. On later ticks it decrements by one.
- R4: A tick that takes the counter from 1 to 0 sets the flag at control bit 16. If a control read occurs in that same cycle, the set wins.
- R5: A read of control/status (offset 0x0) returns the flag and then clears it at the end of the access cycle.
- R6: Any write to the current-value register (offset 0x8) zeroes the counter and the flag, whatever the written data. The next tick reloads the counter and raises no interrupt.
- R7: With a reload value of zero, the counter stays at zero, and neither the flag nor the interrupt fires.
- R8: While `dbg_halt` is high, the counter does not change.
- R9: `irq` is high for exactly one cycle, the cycle after the tick that reached zero, and only when control bit 1 (interrupt enable) was set. Clearing control bit 0 stops counting.
- R10: The reload register (offset 0x4) holds 24 bits. Bits 31:24 of the reload and current-value registers read as zero. A current-value read returns the count in that cycle.
- R11: An access with `bus_word` low, or with address bits 1:0 nonzero, is ignored: no register changes and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick strobe |
| dbg_halt | input | 1 | Freezes the counter while high |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full 32-bit access |
| bus_addr | input | ADDR_W (4) | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the timer with its default parameters: a 24-bit counter, a 4-bit address window and a calibration value of 4. It programs reload values of 5 and 7, so a full wrap, the zero-crossing flag and the interrupt pulse all occur within a handful of accesses. Writing 0xFF000007 to the reload register shows that bits 31:24 are dropped. Because the reload values are small, halt, tick gating, forced clears and a zero reload can be interleaved with counting and compared cycle by cycle.

// File: rtl/tick_pkg.sv
package tick_pkg;
    localparam int DATA_W    = 32;
    localparam int REG_COUNT = 4;
    // register slots, selected by address bits [3:2]
    localparam int IX_CTRL   = 0;
    localparam int IX_LOAD   = 1;
    localparam int IX_CUR    = 2;
    localparam int IX_CAL    = 3;
    // control/status bit positions
    localparam int CTRL_EN   = 0;
    localparam int CTRL_IE   = 1;
    localparam int CTRL_FLAG = 16;
endpackage

// File: rtl/tick_decode.sv
module tick_decode #(
    parameter int ADDR_W = 4,
    parameter int NREG   = 4
) (
    input  logic              sel,
    input  logic              wr,
    input  logic              word,
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   wr_sel,
    output logic [NREG-1:0]   rd_sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic legal;
    assign legal = sel && word && (addr[1:0] == 2'b00);

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_slot
            logic match;
            assign match     = legal && (addr[ADDR_W-1:2] == IDX_W'(i));
            assign wr_sel[i] = match && wr;
            assign rd_sel[i] = match && !wr;
        end
    endgenerate
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        hit = 1'b0;
        if (clr) begin
            s_d.cnt = '0;
        end else if (adv) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = reload;
            end else begin
                s_d.cnt = s_q.cnt - ONE;
                hit     = (s_q.cnt == ONE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          CNT_W     = 24,
    parameter logic [31:0] CALIB_VAL = 32'h0000_0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              dbg_halt,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    typedef struct packed {
        logic             en;
        logic             ie;
        logic             flag;
        logic             irq;
        logic [CNT_W-1:0] reload;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [REG_COUNT-1:0] wr_sel, rd_sel;
    logic [CNT_W-1:0]     cnt_val;
    logic                 hit;
    logic                 adv;
    logic                 en_q, ie_q, flag_q;
    logic [CNT_W-1:0]     reload_q;
    logic                 cur_wr, load_wr;
    logic [DATA_W-1:0]    ctrl_word;
    logic [DATA_W-1:0]    rview [REG_COUNT];

    tick_decode #(.ADDR_W(ADDR_W), .NREG(REG_COUNT)) u_dec (
        .sel    (bus_sel),
        .wr     (bus_wr),
        .word   (bus_word),
        .addr   (bus_addr),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    assign en_q     = st_q.en;
    assign ie_q     = st_q.ie;
    assign flag_q   = st_q.flag;
    assign reload_q = st_q.reload;
    assign cur_wr   = wr_sel[IX_CUR];
    assign load_wr  = wr_sel[IX_LOAD];
    assign adv      = tick_en && en_q && !dbg_halt;

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .clr    (cur_wr),
        .reload (reload_q),
        .cnt    (cnt_val),
        .hit    (hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_sel[IX_CTRL]) begin
            st_d.en = bus_wdata[CTRL_EN];
            st_d.ie = bus_wdata[CTRL_IE];
        end
        if (load_wr) begin
            st_d.reload = bus_wdata[CNT_W-1:0];
        end
        if (rd_sel[IX_CTRL] || cur_wr) begin
            st_d.flag = 1'b0;
        end
        if (hit) begin
            st_d.flag = 1'b1;
            st_d.irq  = st_q.ie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_word            = '0;
        ctrl_word[CTRL_EN]   = st_q.en;
        ctrl_word[CTRL_IE]   = st_q.ie;
        ctrl_word[CTRL_FLAG] = st_q.flag;
    end

    assign rview[IX_CTRL] = ctrl_word;
    assign rview[IX_LOAD] = DATA_W'(st_q.reload);
    assign rview[IX_CUR]  = DATA_W'(cnt_val);
    assign rview[IX_CAL]  = CALIB_VAL;

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (rd_sel[i]) bus_rdata = bus_rdata | rview[i];
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             dbg_halt,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic             flag,
    input logic             en,
    input logic             ie,
    input logic [CNT_W-1:0] reload,
    input logic             cur_wr,
    input logic             load_wr
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cur_wr) |=> $stable(cnt));

    // R8
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !cur_wr) |=> $stable(cnt));

    // R6
    cur_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (cnt == '0 && !flag && !irq));

    // R7
    zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && reload == '0 && !load_wr) |=> (cnt == '0 && !irq));

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick_en && !dbg_halt && !cur_wr && cnt == CNT_W'(1)) |=> flag);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(ie) && flag && cnt == '0));

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .dbg_halt (dbg_halt),
    .irq      (irq),
    .cnt      (cnt_val),
    .flag     (flag_q),
    .en       (en_q),
    .ie       (ie_q),
    .reload   (reload_q),
    .cur_wr   (cur_wr),
    .load_wr  (load_wr)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        dbg_halt = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_word = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int irq_seen = 0;
    bit done = 0;

    typedef struct {
        bit          chk_rd;
        logic [31:0] exp;
        int          irq_exp;
        string       req;
    } sb_item_t;

    sb_item_t sb_q [$];

    always #2 clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_halt(dbg_halt),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    // one bus cycle: drive, queue the expectation, wait for the next falling edge
    task automatic acc(input bit w, input bit wd, input logic [3:0] a,
                       input logic [31:0] d, input bit c, input logic [31:0] e,
                       input int ie, input string r);
        sb_item_t it;
        bus_sel   = 1'b1;
        bus_wr    = w;
        bus_word  = wd;
        bus_addr  = a;
        bus_wdata = d;
        it.chk_rd = c;
        it.exp = e;
        it.irq_exp = ie;
        it.req = r;
        sb_q.push_back(it);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        acc(1'b1, 1'b1, a, d, 1'b0, '0, -1, "");
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input int ie, input string r);
        acc(1'b0, 1'b1, a, '0, 1'b1, e, ie, r);
    endtask

    // monitor: sample mid-cycle, pop and compare
    initial begin
        sb_item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && irq) irq_seen++;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                if (it.chk_rd) begin
                    checks++;
                    if (bus_rdata !== it.exp) begin
                        failures++;
                        $display("FAIL %s rdata actual=%h expected=%h", it.req, bus_rdata, it.exp);
                    end
                end
                if (it.irq_exp >= 0) begin
                    checks++;
                    if (irq !== it.irq_exp[0]) begin
                        failures++;
                        $display("FAIL %s irq actual=%b expected=%0d", it.req, irq, it.irq_exp);
                    end
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd(4'h0, 32'h0, 0, "R1");
        rd(4'h4, 32'h0, -1, "R1");
        rd(4'h8, 32'h0, -1, "R1");
        rd(4'hC, 32'h4, -1, "R1");
        // R3 count and wrap with reload 5
        wr(4'h4, 32'd5);
        wr(4'h0, 32'h3);
        rd(4'h8, 32'd0, -1, "R3");
        rd(4'h8, 32'd5, -1, "R3");
        rd(4'h8, 32'd4, -1, "R2");
        rd(4'h8, 32'd3, -1, "R10");
        rd(4'h8, 32'd2, -1, "R2");
        // R4 set wins over same-cycle read clear
        rd(4'h0, 32'h3, 0, "R4");
        rd(4'h0, 32'h0001_0003, 1, "R9");
        rd(4'h0, 32'h3, 0, "R5");
        // R8 halt
        dbg_halt = 1'b1;
        rd(4'h8, 32'd4, -1, "R8");
        rd(4'h8, 32'd4, -1, "R8");
        dbg_halt = 1'b0;
        rd(4'h8, 32'd4, -1, "R8");
        // R2 tick gating
        tick_en = 1'b0;
        rd(4'h8, 32'd3, -1, "R2");
        rd(4'h8, 32'd3, -1, "R2");
        tick_en = 1'b1;
        rd(4'h8, 32'd3, -1, "R2");
        rd(4'h8, 32'd2, -1, "R3");
        rd(4'h8, 32'd1, 0, "R3");
        // R6 write to current value clears count and flag, no irq on reload
        wr(4'h8, 32'h00AB_CDEF);
        rd(4'h0, 32'h3, 0, "R6");
        rd(4'h8, 32'd5, 0, "R6");
        // R7 zero reload parks at zero
        wr(4'h4, 32'd0);
        wr(4'h8, 32'h1234_5678);
        rd(4'h8, 32'd0, 0, "R7");
        rd(4'h8, 32'd0, 0, "R7");
        rd(4'h0, 32'h3, 0, "R7");
        rd(4'h8, 32'd0, 0, "R7");
        // R10 upper bits dropped
        wr(4'h4, 32'hFF00_0007);
        rd(4'h4, 32'h7, -1, "R10");
        // R11 illegal accesses ignored
        acc(1'b1, 1'b0, 4'h4, 32'd9, 1'b0, '0, -1, "");
        rd(4'h4, 32'h7, -1, "R11");
        acc(1'b1, 1'b1, 4'h5, 32'd9, 1'b0, '0, -1, "");
        rd(4'h4, 32'h7, -1, "R11");
        acc(1'b0, 1'b0, 4'h4, '0, 1'b1, 32'h0, -1, "R11");
        // R9 no irq with interrupt enable clear, flag still sets
        wr(4'h0, 32'h1);
        wr(4'h8, 32'h0);
        rd(4'h8, 32'd0, -1, "R3");
        for (int v = 7; v >= 1; v--) rd(4'h8, 32'(v), 0, "R9");
        rd(4'h0, 32'h0001_0001, 0, "R9");
        rd(4'h0, 32'h1, 0, "R5");
        // R9 enable off stops counting
        wr(4'h0, 32'h0);
        rd(4'h8, 32'd5, -1, "R9");
        rd(4'h8, 32'd5, -1, "R9");
        @(negedge clk);
        checks++;
        if (irq_seen != 2) begin
            failures++;
            $display("FAIL R9 irq pulse count actual=%0d expected=2", irq_seen);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule